// File: doc/BRIEF.md
# Checkpoint Coordinator Sequencer

This block orders a system-wide save point across a set of cache/core nodes and a set of memory loggers. A save point starts when an external request pulse arrives or when an internal periodic timer expires. The block then raises one global level, and every participant begins copying its state in parallel. The block holds the level until every participant has reported completion. It then lowers the level, and this falling edge tells all participants to commit at the same time: the cache/core nodes switch banks and the loggers write a boundary mark. After one commit cycle the block returns to idle.

A request that arrives while a save point is running is held. It starts a new save point as soon as the block is idle again. Completed commits are counted in a wrapping counter. During power-up recovery a level input marks that state is being restored. The block forwards it as a registered notification bit for the processors, and it starts no save point while recovery is active.

Top module: `ckpt_coordinator`

## Requirements
- R1: After a clock edge with `rst_n` low, `ckpt_level`, `ckpt_busy`, `restore_note` and `ckpt_count` are all 0.
- R2: When `ckpt_req` is high at rising edge k and the block is idle with `recover` low, `ckpt_level` and `ckpt_busy` are high after edge k+1.
- R3: The internal timer expires at every TICK_PERIOD-th rising edge after reset is released. Each expiry acts exactly like an external request.
- R4: `ckpt_level` falls at the first edge in the collect phase at which every participant has reported done. The collect phase is every cycle after the first level-high cycle. `ckpt_level` never falls before that edge.
- R5: A participant's done flag needs to be high for only one collect-phase cycle. The flag is remembered until that save point commits, so participants may report at different cycles.
- R6: Done flags seen in the first cycle of a raised level, or while idle or committing, are ignored. A save point whose participants report only then keeps `ckpt_level` high.
- R7: After `ckpt_level` falls, `ckpt_busy` stays high for exactly one more cycle, the commit cycle, and then falls.
- R8: `ckpt_count` increases by 1, modulo 2^CNT_W, at the same edge at which `ckpt_busy` falls. It does not change at any other time.
- R9: A request or timer expiry that arrives while busy is held. The next save point starts at the first edge after `ckpt_busy` falls. Several held requests merge into one save point.
- R10: `restore_note` equals `recover` delayed by one edge. While `recover` is high, no save point starts, and held requests stay held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ckpt_req | input | 1 | External save point request, sampled each edge |
| node_done | input | N_NODES | Per cache/core node completion flags |
| log_done | input | N_LOGS | Per memory logger flush-complete flags |
| recover | input | 1 | High while the system is restoring state |
| ckpt_level | output | 1 | Global save point level: high = copy, falling = commit |
| ckpt_busy | output | 1 | High from the raise of the level through the commit cycle |
| ckpt_count | output | CNT_W | Number of completed commits, wrapping |
| restore_note | output | 1 | Registered recovery notification for processors |

## Verification
A request sampled at edge k shows on `ckpt_level` after edge k+1. A final done flag sampled at a collect-phase edge drops the level at that same edge. The counter and `ckpt_busy` change one edge after the level falls, and `restore_note` trails `recover` by one edge. The bench runs a cycle-stepped model of these requirements that updates on each rising edge from the inputs held since the preceding falling edge. It compares every output at the following falling edge, so each result is checked in the exact cycle in which it is due. Directed checks of the reset state and of the request-to-level latency count edges explicitly before they sample.

// File: rtl/ckpt_coord_pkg.sv
// Package: shared types for the save point coordinator.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package ckpt_coord_pkg;

    // Sequencer phases: idle, first raised cycle, collecting done flags, commit cycle.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RAISE   = 2'd1,
        PH_COLLECT = 2'd2,
        PH_COMMIT  = 2'd3
    } ckpt_phase_e;

endpackage

// File: rtl/ckpt_trigger.sv
// Module: ckpt_trigger
// Merges the external request and a periodic timer expiry into one held
// "pending" flag that is cleared when the sequencer takes it.
// Assumes: TICK_PERIOD >= 2; take_i is only high when pending_o is high.
module ckpt_trigger #(
    parameter int TICK_PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    output logic pending_o
);
    localparam int TW = $clog2(TICK_PERIOD);
    localparam logic [TW-1:0] LAST = TW'(TICK_PERIOD - 1);

    logic [TW-1:0] tick_cnt_q;
    logic          tick;
    logic          pend_q;

    assign tick      = (tick_cnt_q == LAST);
    assign pending_o = pend_q;

    // Free-running period counter that wraps after TICK_PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_cnt_q <= '0;
        else if (tick) tick_cnt_q <= '0;
        else           tick_cnt_q <= tick_cnt_q + TW'(1);
    end

    // Pending flag: a new request or expiry wins over the take that clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend_q <= 1'b0;
        else if (req_i || tick)  pend_q <= 1'b1;
        else if (take_i)         pend_q <= 1'b0;
    end

    // R9: a held request stays held until the sequencer takes it.
    a_r9_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take_i) |=> pend_q);

    // R3: an expiry always leaves a request pending.
    a_r3_tick_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pend_q);

endmodule

// File: rtl/ckpt_done_collect.sv
// Module: ckpt_done_collect
// Remembers per-participant done flags during the collect phase and reports
// when every participant has completed (stored flag or live flag).
// Assumes: clear_i and capture_i are never high in the same cycle.
module ckpt_done_collect #(
    parameter int N_PART = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic [N_PART-1:0] done_i,
    output logic              all_done_o
);
    logic [N_PART-1:0] seen_q;
    logic [N_PART-1:0] seen_or_live;

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        // One sticky bit per participant: cleared on raise, set by done while collecting.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)          seen_q[p] <= 1'b0;
            else if (capture_i && done_i[p]) seen_q[p] <= 1'b1;
        end
        assign seen_or_live[p] = seen_q[p] | done_i[p];
    end

    // Completion only counts while collecting.
    assign all_done_o = capture_i && (&seen_or_live);

    // R6: the raise cycle leaves no stale completion behind.
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (seen_q == '0));

    // R5: a remembered flag survives until the next clear.
    a_r5_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i) |=> ((seen_q & $past(seen_q)) == $past(seen_q)));

endmodule

// File: rtl/ckpt_phase_fsm.sv
// Module: ckpt_phase_fsm
// Sequences one save point: idle -> raise (1 cycle) -> collect (until all
// done) -> commit (1 cycle) -> idle, and counts completed commits.
// Assumes: all_done_i is only asserted while capture_o is high.
module ckpt_phase_fsm
    import ckpt_coord_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending_i,
    input  logic             recover_i,
    input  logic             all_done_i,
    output logic             take_o,
    output logic             clear_o,
    output logic             capture_o,
    output logic             level_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] count_o
);
    ckpt_phase_e phase_q, phase_d;
    logic [CNT_W-1:0] count_q;

    assign take_o    = (phase_q == PH_IDLE) && pending_i && !recover_i;
    assign clear_o   = (phase_q == PH_RAISE);
    assign capture_o = (phase_q == PH_COLLECT);
    assign level_o   = (phase_q == PH_RAISE) || (phase_q == PH_COLLECT);
    assign busy_o    = (phase_q != PH_IDLE);
    assign count_o   = count_q;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (take_o)     phase_d = PH_RAISE;
            PH_RAISE:                   phase_d = PH_COLLECT;
            PH_COLLECT: if (all_done_i) phase_d = PH_COMMIT;
            PH_COMMIT:                  phase_d = PH_IDLE;
            default:                    phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Commit counter: steps as the commit cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count_q <= '0;
        else if (phase_q == PH_COMMIT) count_q <= count_q + CNT_W'(1);
    end

    // R7: the commit phase lasts exactly one cycle.
    a_r7_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_COMMIT) |=> (phase_q == PH_IDLE));

    // R4: the level only falls on a full completion.
    a_r4_fall_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_o) |-> $past(all_done_i));

    // R8: the count steps by one exactly when busy falls.
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (count_q == $past(count_q) + CNT_W'(1)));

    // R8: no change of count while busy is not falling.
    a_r8_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_COMMIT) |=> $stable(count_q));

    // R10: no save point begins while recovering.
    a_r10_no_start_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && recover_i) |=> (phase_q == PH_IDLE));

    // R2: the raise phase always follows an accepted start.
    a_r2_raise_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (phase_q == PH_RAISE));

endmodule

// File: rtl/ckpt_coordinator.sv
// Module: ckpt_coordinator (top)
// Coordinates a global two-phase save point across N_NODES cache/core nodes
// and N_LOGS memory loggers, and forwards the recovery notification.
// Assumes: participants drop their done flags after seeing the level fall.
module ckpt_coordinator #(
    parameter int N_NODES     = 4,
    parameter int N_LOGS      = 2,
    parameter int TICK_PERIOD = 1000,
    parameter int CNT_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ckpt_req,
    input  logic [N_NODES-1:0] node_done,
    input  logic [N_LOGS-1:0]  log_done,
    input  logic               recover,
    output logic               ckpt_level,
    output logic               ckpt_busy,
    output logic [CNT_W-1:0]   ckpt_count,
    output logic               restore_note
);
    localparam int N_PART = N_NODES + N_LOGS;

    logic pending, take, clear, capture, all_done;
    logic restore_q;
    logic [N_PART-1:0] part_done;

    assign part_done    = {log_done, node_done};
    assign restore_note = restore_q;

    ckpt_trigger #(.TICK_PERIOD(TICK_PERIOD)) i_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (ckpt_req),
        .take_i    (take),
        .pending_o (pending)
    );

    ckpt_done_collect #(.N_PART(N_PART)) i_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .capture_i  (capture),
        .done_i     (part_done),
        .all_done_o (all_done)
    );

    ckpt_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_i  (pending),
        .recover_i  (recover),
        .all_done_i (all_done),
        .take_o     (take),
        .clear_o    (clear),
        .capture_o  (capture),
        .level_o    (ckpt_level),
        .busy_o     (ckpt_busy),
        .count_o    (ckpt_count)
    );

    // Registered recovery notification toward the processors.
    always_ff @(posedge clk) begin
        if (!rst_n) restore_q <= 1'b0;
        else        restore_q <= recover;
    end

    // R10: the notification trails the recovery input by one edge.
    a_r10_restore_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_q) |-> $past(recover));

    // R7: the level is never high without busy.
    a_r7_level_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_level |-> ckpt_busy);

endmodule

// File: tb/test_ckpt_coordinator.sv
// Bench: cycle-stepped requirement model plus directed checks.
module test_ckpt_coordinator;
    localparam int NN = 3;
    localparam int NL = 2;
    localparam int NP = NN + NL;
    localparam int TP = 97;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [NN-1:0] nd = '0;
    logic [NL-1:0] ld = '0;
    logic rec = 1'b0;
    logic lvl, bsy, rnote;
    logic [CW-1:0] cnt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;   // 125 MHz

    ckpt_coordinator #(.N_NODES(NN), .N_LOGS(NL), .TICK_PERIOD(TP), .CNT_W(CW)) i_ckpt_coordinator (
        .clk(clk), .rst_n(rst_n), .ckpt_req(req), .node_done(nd), .log_done(ld),
        .recover(rec), .ckpt_level(lvl), .ckpt_busy(bsy), .ckpt_count(cnt), .restore_note(rnote)
    );

    // Reference model state: 0 idle, 1 raise, 2 collect, 3 commit.
    int m_ph = 0;
    int m_tick = 0;
    bit m_pend = 0;
    bit m_rest = 0;
    logic [NP-1:0] m_seen = '0;
    logic [CW-1:0] m_cnt = '0;

    function automatic bit exp_level(int ph);
        return (ph == 1 || ph == 2);
    endfunction

    // Model advances at each rising edge from inputs held since the falling edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_tick = 0; m_pend = 0; m_rest = 0; m_seen = '0; m_cnt = '0;
        end else begin
            bit tk, take, alld;
            logic [NP-1:0] d;
            d    = {ld, nd};
            tk   = (m_tick == TP - 1);
            take = (m_ph == 0) && m_pend && !rec;
            alld = (m_ph == 2) && ((m_seen | d) == '1);
            m_tick = tk ? 0 : m_tick + 1;
            m_pend = (req || tk) ? 1'b1 : (take ? 1'b0 : m_pend);
            if (m_ph == 1) m_seen = '0;
            else if (m_ph == 2) m_seen = m_seen | d;
            m_rest = rec;
            case (m_ph)
                0: if (take) m_ph = 1;
                1: m_ph = 2;
                2: if (alld) m_ph = 3;
                default: begin m_ph = 0; m_cnt = m_cnt + 1'b1; end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2 R3 R4 R5 R6 R9 ckpt_level", int'(lvl), int'(exp_level(m_ph)));
        chk("R7 R9 ckpt_busy", int'(bsy), int'(m_ph != 0));
        chk("R8 ckpt_count", int'(cnt), int'(m_cnt));
        chk("R10 restore_note", int'(rnote), int'(m_rest));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 level", int'(lvl), 0);
        chk("R1 busy", int'(bsy), 0);
        chk("R1 count", int'(cnt), 0);
        chk("R1 restore", int'(rnote), 0);
        rst_n = 1'b1;
        @(negedge clk); cmp_all();

        // R2: request sampled at edge k -> level high after edge k+1
        req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk("R2 level not yet", int'(lvl), 0);
        @(negedge clk);
        chk("R2 level raised", int'(lvl), 1);
        // R6: done during the raise cycle is ignored
        nd = '1; ld = '1;
        @(negedge clk); nd = '0; ld = '0;
        chk("R6 level held after raise-cycle done", int'(lvl), 1);
        cmp_all();
        // R5: staggered one-cycle pulses; R9: request while busy
        nd = 3'b001; req = 1'b1;
        @(negedge clk); nd = 3'b110; ld = 2'b01; req = 1'b0;
        cmp_all();
        @(negedge clk); nd = '0; ld = 2'b10;
        cmp_all();
        @(negedge clk); ld = '0;
        chk("R4 R5 level fell on last done", int'(lvl), 0);
        chk("R7 busy in commit", int'(bsy), 1);
        @(negedge clk);
        chk("R7 busy fell", int'(bsy), 0);
        chk("R8 count stepped", int'(cnt), 1);
        @(negedge clk);
        chk("R9 held request started", int'(lvl), 1);

        // Random phase
        for (int i = 0; i < 8000; i++) begin
            req = ($urandom_range(0, 39) == 0);
            nd  = NN'($urandom()) & NN'($urandom());
            ld  = NL'($urandom()) & NL'($urandom());
            if ($urandom_range(0, 299) == 0) rec = ~rec;
            @(negedge clk);
            cmp_all();
        end
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule